// File: doc/BRIEF.md
# Multi-Mode Timer Counter

A 24-bit programmable timer that shares one counter between timing, pin-output, event-counting, measurement and watchdog behaviour. Software programs a control word, a load value and a compare value through a small register port, starts the timer, and reads the live count or a captured value at any time. Counting advances on an internal clock-enable strobe (`tick`) or, in event mode, on active edges of the timer pin. The pin is modelled as a separate input, output and output-enable.

Every count event either loads the load value (the first event after start, or the event after a compare match in reloading modes) or adds one. Reaching the compare value sets a compare flag. Wrapping past all-ones sets an overflow flag. Each flag drives an interrupt line through its own enable. The three measurement modes ignore the compare value. They latch the running count into a capture register on pin edges and use the compare flag to signal a fresh capture.

Register map (3-bit address): 0 control/status, 1 load, 2 compare, 3 live count (read only), 4 capture (read only). Control bits: 0 run, 1 compare interrupt enable, 2 overflow interrupt enable, 3 pin polarity invert, 7:4 mode, 8 compare flag, 9 overflow flag.

Top module: `mm_timer`

## Requirements
- R1: Mode codes are 0 timer, 1 pulse out, 2 toggle out, 3 event count, 4 width, 5 period, 6 capture, 7 PWM, 9 watchdog pulse, 10 watchdog toggle; codes 8 and 11 to 15 leave the counter idle at its start value.
- R2: A control write that raises run (bit 0) from 0 clears the count to 0; while run is 0 the count holds its value.
- R3: In counting modes the first count event after start loads the load register; each later event adds one.
- R4: In modes 0, 1, 2, 3 and 7 an event whose new count equals the compare register sets the compare flag (bit 8), and the next event reloads the load value; irq_cmp is high while the flag and bit 1 are both set.
- R5: An increment from 0xFFFFFF wraps to 0 and sets the overflow flag (bit 9); irq_ovf is high while the flag and bit 2 are both set.
- R6: A control write with 1 in a flag bit clears that flag; writing 0 there leaves it set.
- R7: While run is set, control writes leave the mode field (bits 7:4) and polarity (bit 3) unchanged.
- R8: The count register (address 3) can be read at any time, and reading it does not alter the count.
- R9: In mode 3 the counter advances on active pin edges (after a two-stage synchroniser) and ignores tick.
- R10: In mode 4, with tick held high, an active pin pulse of W clock cycles leaves load+W-1 in both the capture register (address 4) and the count; the compare flag marks the capture and the compare value has no effect.
- R11: In mode 5, with tick held high, active edges P cycles apart capture load+P-1; in mode 6 the first active edge latches the count and freezes it, and later edges change nothing.
- R12: Modes 1, 2 and 7 drive the pin (pin_oe high): mode 1 gives a one-cycle pulse after a match, mode 2 toggles on each match, mode 7 goes active on reload and inactive on a match; polarity bit 3 inverts the pin.
- R13: In mode 9 an overflow gives a one-cycle pin pulse, in mode 10 it toggles the pin; a load-register write while running restarts the count at the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Internal count enable strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data for `addr` (combinational) |
| pin_in | input | 1 | Timer pin input level |
| pin_out | output | 1 | Timer pin output level |
| pin_oe | output | 1 | Timer pin output enable |
| irq_cmp | output | 1 | Compare interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach from the ports is a counter crossing all-ones while the compare and reload logic is also active, because random load values almost never land near the top of the 24-bit range. The random stimulus therefore draws load values either just below the compare value or within a few counts of 0xFFFFFF. Each run is checked against a bench model of the count, compare flag and overflow flag. The measurement modes depend on exact pulse widths through the pin synchroniser, so they use directed pin waveforms with tick held high. This makes the expected capture values exact.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  localparam logic [3:0] MD_TIMER     = 4'd0;
  localparam logic [3:0] MD_PULSE     = 4'd1;
  localparam logic [3:0] MD_TOGGLE    = 4'd2;
  localparam logic [3:0] MD_EVENT     = 4'd3;
  localparam logic [3:0] MD_WIDTH     = 4'd4;
  localparam logic [3:0] MD_PERIOD    = 4'd5;
  localparam logic [3:0] MD_CAPTURE   = 4'd6;
  localparam logic [3:0] MD_PWM       = 4'd7;
  localparam logic [3:0] MD_WD_PULSE  = 4'd9;
  localparam logic [3:0] MD_WD_TOGGLE = 4'd10;

  localparam int A_CTRL  = 0;
  localparam int A_LOAD  = 1;
  localparam int A_CMP   = 2;
  localparam int A_COUNT = 3;
  localparam int A_CAPT  = 4;

  localparam int B_RUN  = 0;
  localparam int B_CIE  = 1;
  localparam int B_OIE  = 2;
  localparam int B_POL  = 3;
  localparam int B_MODE = 4;
  localparam int B_CFLG = 8;
  localparam int B_OFLG = 9;

  typedef struct packed {
    logic       run;
    logic       cie;
    logic       oie;
    logic       pol;
    logic [3:0] mode;
  } ctrl_t;

endpackage

// File: rtl/mmt_regs.sv
module mmt_regs
  import mmt_pkg::*;
#(
  parameter int CW = 24,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  input  logic          cmp_set,
  input  logic          ovf_set,
  output ctrl_t         ctrl_q,
  output logic [CW-1:0] load_q,
  output logic [CW-1:0] cmp_q,
  output logic          cmp_flag,
  output logic          ovf_flag,
  output logic          start,
  output logic          load_wr
);

  logic  ctrl_wr, cmp_wr;
  ctrl_t ctrl_d;
  logic  cflag_d, oflag_d;

  assign ctrl_wr = wr_en && (addr == AW'(A_CTRL));
  assign load_wr = wr_en && (addr == AW'(A_LOAD));
  assign cmp_wr  = wr_en && (addr == AW'(A_CMP));
  assign start   = ctrl_wr && wdata[B_RUN] && !ctrl_q.run;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.run = wdata[B_RUN];
      ctrl_d.cie = wdata[B_CIE];
      ctrl_d.oie = wdata[B_OIE];
      if (!ctrl_q.run) begin
        ctrl_d.pol  = wdata[B_POL];
        ctrl_d.mode = wdata[B_MODE+3:B_MODE];
      end
    end
    cflag_d = cmp_set | (cmp_flag & ~(ctrl_wr & wdata[B_CFLG]));
    oflag_d = ovf_set | (ovf_flag & ~(ctrl_wr & wdata[B_OFLG]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      cmp_flag <= cflag_d;
      ovf_flag <= oflag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (load_wr) begin
      load_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (cmp_wr) begin
      cmp_q <= wdata;
    end
  end

  // R7: mode stays fixed across consecutive running cycles
  assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.run && $past(ctrl_q.run)) |-> ($stable(ctrl_q.mode) && $stable(ctrl_q.pol)));

  // R4: a compare flag can only appear after a running cycle
  assert_cflag_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> $past(ctrl_q.run));

endmodule

// File: rtl/mmt_edge.sv
module mmt_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic pol,
  output logic lvl,
  output logic lead,
  output logic trail
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, raw, rise, fall;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = pin_in;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], pin_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= raw;
    end
  end

  assign raw   = sync_q[STAGES-1];
  assign rise  = raw & ~prev_q;
  assign fall  = ~raw & prev_q;
  assign lvl   = raw ^ pol;
  assign lead  = pol ? fall : rise;
  assign trail = pol ? rise : fall;

  // R9: leading and trailing edges never coincide
  assert_edges_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead && trail));

endmodule

// File: rtl/mmt_core.sv
module mmt_core
  import mmt_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  ctrl_t         ctrl,
  input  logic          start,
  input  logic          load_wr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] load_q,
  input  logic [CW-1:0] cmp_q,
  input  logic          lvl,
  input  logic          lead,
  input  logic          trail,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cap_q,
  output logic          cmp_set,
  output logic          ovf_set,
  output logic          pin_out,
  output logic          pin_oe
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [3:0]    md;
  logic          meas_md, reload_md, wd_md, pulse_md, cnt_ev;
  logic [CW-1:0] cnt_d, cap_d, inc, nv;
  logic          at_max, reload;
  logic          first_q, first_d, armed_q, armed_d, done_q, done_d, out_q, out_d;

  assign md        = ctrl.mode;
  assign meas_md   = md inside {MD_WIDTH, MD_PERIOD, MD_CAPTURE};
  assign reload_md = md inside {MD_TIMER, MD_PULSE, MD_TOGGLE, MD_EVENT, MD_PWM};
  assign wd_md     = md inside {MD_WD_PULSE, MD_WD_TOGGLE};
  assign pulse_md  = md inside {MD_PULSE, MD_WD_PULSE};
  assign pin_oe    = md inside {MD_PULSE, MD_TOGGLE, MD_PWM, MD_WD_PULSE, MD_WD_TOGGLE};
  assign cnt_ev    = (reload_md | wd_md) & ((md == MD_EVENT) ? lead : tick);
  assign inc       = cnt_q + ONE;
  assign at_max    = &cnt_q;
  assign pin_out   = out_q ^ ctrl.pol;

  always_comb begin
    cnt_d   = cnt_q;
    cap_d   = cap_q;
    first_d = first_q;
    armed_d = armed_q;
    done_d  = done_q;
    out_d   = out_q;
    cmp_set = 1'b0;
    ovf_set = 1'b0;
    nv      = cnt_q;
    reload  = 1'b0;
    if (pulse_md) out_d = 1'b0;
    if (start) begin
      cnt_d   = '0;
      first_d = 1'b1;
      armed_d = 1'b0;
      done_d  = 1'b0;
      out_d   = 1'b0;
    end else if (ctrl.run) begin
      if (wd_md && load_wr) begin
        cnt_d   = wdata;
        first_d = 1'b0;
      end else if (meas_md) begin
        case (md)
          MD_WIDTH: begin
            if (lead) begin
              cnt_d = load_q;
            end else if (trail) begin
              cap_d   = cnt_q;
              cmp_set = 1'b1;
            end else if (tick && lvl) begin
              cnt_d   = inc;
              ovf_set = at_max;
            end
          end
          MD_PERIOD: begin
            if (lead) begin
              if (armed_q) begin
                cap_d   = cnt_q;
                cmp_set = 1'b1;
              end
              cnt_d   = load_q;
              armed_d = 1'b1;
            end else if (tick && armed_q) begin
              cnt_d   = inc;
              ovf_set = at_max;
            end
          end
          default: begin
            if (!done_q) begin
              if (lead) begin
                cap_d   = cnt_q;
                cmp_set = 1'b1;
                done_d  = 1'b1;
              end else if (tick) begin
                if (first_q) begin
                  cnt_d   = load_q;
                  first_d = 1'b0;
                end else begin
                  cnt_d   = inc;
                  ovf_set = at_max;
                end
              end
            end
          end
        endcase
      end else if (cnt_ev) begin
        if (first_q) begin
          nv      = load_q;
          first_d = 1'b0;
          reload  = 1'b1;
        end else if (reload_md && (cnt_q == cmp_q)) begin
          nv     = load_q;
          reload = 1'b1;
        end else begin
          nv      = inc;
          ovf_set = at_max;
        end
        cnt_d   = nv;
        cmp_set = (nv == cmp_q);
        case (md)
          MD_PULSE:     out_d = cmp_set;
          MD_TOGGLE:    if (cmp_set) out_d = ~out_q;
          MD_PWM: begin
            if (cmp_set)     out_d = 1'b0;
            else if (reload) out_d = 1'b1;
          end
          MD_WD_PULSE:  out_d = ovf_set;
          MD_WD_TOGGLE: if (ovf_set) out_d = ~out_q;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cap_q   <= '0;
      first_q <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cap_q   <= cap_d;
      first_q <= first_d;
      armed_q <= armed_d;
      done_q  <= done_d;
      out_q   <= out_d;
    end
  end

  // R2: a start leaves the count at zero
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0));

  // R2: a stopped timer holds its count
  assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !start) |=> $stable(cnt_q));

  // R5: an overflow is followed by a count of zero
  assert_ovf_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> (cnt_q == '0));

  // R10: the capture register only moves in measurement modes
  assert_cap_only_meas_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q != $past(cap_q)) |-> $past(meas_md));

endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import mmt_pkg::*;
#(
  parameter int CW          = 24,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          irq_cmp,
  output logic          irq_ovf
);

  logic [1:0]    rs_q;
  logic          rst_core_n;
  ctrl_t         ctrl_q;
  logic [CW-1:0] load_q, cmp_q, cnt_q, cap_q;
  logic          cmp_flag, ovf_flag, cmp_set, ovf_set, start, load_wr;
  logic          lvl, lead, trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  mmt_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cmp_set(cmp_set), .ovf_set(ovf_set), .ctrl_q(ctrl_q), .load_q(load_q),
    .cmp_q(cmp_q), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .start(start),
    .load_wr(load_wr)
  );

  mmt_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_core_n), .pin_in(pin_in), .pol(ctrl_q.pol),
    .lvl(lvl), .lead(lead), .trail(trail)
  );

  mmt_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .ctrl(ctrl_q), .start(start),
    .load_wr(load_wr), .wdata(wdata), .load_q(load_q), .cmp_q(cmp_q),
    .lvl(lvl), .lead(lead), .trail(trail), .cnt_q(cnt_q), .cap_q(cap_q),
    .cmp_set(cmp_set), .ovf_set(ovf_set), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign irq_cmp = cmp_flag & ctrl_q.cie;
  assign irq_ovf = ovf_flag & ctrl_q.oie;

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_CTRL): begin
        rdata[B_RUN]             = ctrl_q.run;
        rdata[B_CIE]             = ctrl_q.cie;
        rdata[B_OIE]             = ctrl_q.oie;
        rdata[B_POL]             = ctrl_q.pol;
        rdata[B_MODE+3:B_MODE]   = ctrl_q.mode;
        rdata[B_CFLG]            = cmp_flag;
        rdata[B_OFLG]            = ovf_flag;
      end
      AW'(A_LOAD):  rdata = load_q;
      AW'(A_CMP):   rdata = cmp_q;
      AW'(A_COUNT): rdata = cnt_q;
      AW'(A_CAPT):  rdata = cap_q;
      default: ;
    endcase
  end

endmodule

// File: tb/sim_mm_timer.sv
module sim_mm_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 24;

  logic          clk, rst_n, tick, wr_en, pin_in;
  logic [2:0]    addr;
  logic [CW-1:0] wdata, rdata;
  logic          pin_out, pin_oe, irq_cmp, irq_ovf;
  int            nchk = 0;
  int            nfail = 0;
  bit            finished = 0;

  mm_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cw(input bit run, input bit cie, input bit oie,
                                       input bit pol, input logic [3:0] mode);
    logic [CW-1:0] v;
    v = '0;
    v[0] = run; v[1] = cie; v[2] = oie; v[3] = pol; v[7:4] = mode;
    return v;
  endfunction

  // expected count and flags for a reloading timer after k tick events
  function automatic void exp_timer(input logic [CW-1:0] ld, input logic [CW-1:0] cp,
                                    input int k, output logic [CW-1:0] c,
                                    output bit cf, output bit of);
    bit first;
    c = '0; first = 1; cf = 0; of = 0;
    for (int i = 0; i < k; i++) begin
      if (first) begin
        c = ld; first = 0;
      end else if (c == cp) begin
        c = ld;
      end else begin
        if (c == '1) of = 1;
        c = c + 1'b1;
      end
      if (c == cp) cf = 1;
    end
  endfunction

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_pin(input int hi, input int lo);
    @(negedge clk); pin_in = 1'b1;
    repeat (hi) @(negedge clk);
    pin_in = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic stop();
    wr(3'd0, 24'h000300);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v, v2, ld, cp, ec;
    bit cf, of;
    int k;
    void'($urandom(32'd90210));
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; pin_in = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    rd(3'd0, v); chk("R2 reset ctrl", v, 24'h0);
    rd(3'd3, v); chk("R2 reset count", v, 24'h0);
    chk("R5 reset irqs", {22'h0, irq_cmp, irq_ovf}, 24'h0);
    chk("R12 reset pin_oe", {23'h0, pin_oe}, 24'h0);

    // R3 basic counting, R8 reads do not disturb
    wr(3'd1, 24'd10); wr(3'd2, 24'd1000);
    wr(3'd0, cw(1, 1, 1, 0, 4'd0));
    ticks(5);
    rd(3'd3, v); chk("R3 count after 5 events", v, 24'd14);
    rd(3'd3, v); chk("R8 repeated read", v, 24'd14);
    ticks(1);
    rd(3'd3, v); chk("R8 count after extra event", v, 24'd15);

    // R7 mode and polarity locked while running
    wr(3'd0, cw(1, 1, 1, 1, 4'd7));
    rd(3'd0, v); chk("R7 mode locked", v, cw(1, 1, 1, 0, 4'd0));

    // R2 stop holds, restart clears
    wr(3'd0, cw(0, 1, 1, 0, 4'd0));
    ticks(3);
    rd(3'd3, v); chk("R2 stopped count holds", v, 24'd15);
    wr(3'd0, cw(1, 1, 1, 0, 4'd0));
    rd(3'd3, v); chk("R2 start clears", v, 24'd0);

    // R1 reserved mode stays idle
    stop();
    wr(3'd0, cw(1, 0, 0, 0, 4'd8));
    ticks(4);
    rd(3'd3, v); chk("R1 reserved mode idle", v, 24'd0);

    // R4 compare and reload, R6 flag clearing
    stop();
    wr(3'd1, 24'd5); wr(3'd2, 24'd7);
    wr(3'd0, cw(1, 1, 0, 0, 4'd0));
    ticks(3);
    rd(3'd0, v); chk("R4 compare flag set", {23'h0, v[8]}, 24'd1);
    chk("R4 irq_cmp", {23'h0, irq_cmp}, 24'd1);
    wr(3'd0, cw(1, 1, 0, 0, 4'd0));
    rd(3'd0, v); chk("R6 write 0 keeps flag", {23'h0, v[8]}, 24'd1);
    wr(3'd0, cw(1, 1, 0, 0, 4'd0) | 24'h100);
    rd(3'd0, v); chk("R6 write 1 clears flag", {23'h0, v[8]}, 24'd0);
    chk("R6 irq_cmp low", {23'h0, irq_cmp}, 24'd0);
    ticks(1);
    rd(3'd3, v); chk("R4 reload after match", v, 24'd5);

    // R5 overflow directed
    stop();
    wr(3'd1, 24'hFFFFFD); wr(3'd2, 24'd5);
    wr(3'd0, cw(1, 0, 1, 0, 4'd0));
    ticks(4);
    rd(3'd3, v); chk("R5 wrap to zero", v, 24'd0);
    rd(3'd0, v); chk("R5 overflow flag", {23'h0, v[9]}, 24'd1);
    chk("R5 irq_ovf", {23'h0, irq_ovf}, 24'd1);

    // R3 R4 R5 random runs against the model
    for (int it = 0; it < 24; it++) begin
      case ($urandom % 3)
        0: begin ld = 24'($urandom % 64); cp = ld + 24'($urandom % 40); end
        1: begin ld = 24'hFFFFFF - 24'($urandom % 20); cp = 24'($urandom % 10); end
        default: begin ld = 24'($urandom); cp = 24'($urandom); end
      endcase
      k = (it == 0) ? 0 : int'($urandom % 60) + 1;
      stop();
      wr(3'd1, ld); wr(3'd2, cp);
      wr(3'd0, cw(1, 1, 1, 0, 4'd0));
      ticks(k);
      exp_timer(ld, cp, k, ec, cf, of);
      rd(3'd3, v);  chk("R3 random count", v, ec);
      rd(3'd0, v2);
      chk("R4 random compare flag", {23'h0, v2[8]}, {23'h0, cf});
      chk("R5 random overflow flag", {23'h0, v2[9]}, {23'h0, of});
      chk("R4 random irq_cmp", {23'h0, irq_cmp}, {23'h0, cf});
      chk("R5 random irq_ovf", {23'h0, irq_ovf}, {23'h0, of});
    end

    // R9 event counting on pin edges, tick ignored
    stop();
    wr(3'd1, 24'd100);
    wr(3'd0, cw(1, 0, 0, 0, 4'd3));
    tick = 1'b1;
    repeat (5) pulse_pin(3, 3);
    repeat (5) @(negedge clk);
    tick = 1'b0;
    rd(3'd3, v); chk("R9 event count", v, 24'd104);

    // R10 width measurement
    stop();
    wr(3'd1, 24'd50); wr(3'd2, 24'd52);
    wr(3'd0, cw(1, 0, 0, 0, 4'd4));
    tick = 1'b1;
    repeat (4) @(negedge clk);
    pulse_pin(7, 5);
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk("R10 width capture", v, 24'd56);
    rd(3'd3, v); chk("R10 count ignores compare", v, 24'd56);
    rd(3'd0, v); chk("R10 capture flag", {23'h0, v[8]}, 24'd1);
    tick = 1'b0;

    // R11 period measurement
    stop();
    wr(3'd1, 24'd0);
    wr(3'd0, cw(1, 0, 0, 0, 4'd5));
    tick = 1'b1;
    repeat (3) pulse_pin(4, 9);
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk("R11 period capture", v, 24'd12);

    // R11 capture mode
    stop();
    wr(3'd1, 24'd200);
    wr(3'd0, cw(1, 0, 0, 0, 4'd6));
    repeat (10) @(negedge clk);
    pulse_pin(2, 2);
    repeat (5) @(negedge clk);
    rd(3'd4, v); rd(3'd3, v2);
    chk("R11 capture freezes count", v2, v);
    chk("R11 capture above load", {23'h0, (v >= 24'd200)}, 24'd1);
    pulse_pin(2, 2);
    repeat (5) @(negedge clk);
    rd(3'd4, v2); chk("R11 later edge ignored", v2, v);
    tick = 1'b0;

    // R12 pulse output
    stop();
    wr(3'd1, 24'd0); wr(3'd2, 24'd3);
    wr(3'd0, cw(1, 0, 0, 0, 4'd1));
    ticks(3);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R12 pulse high", {22'h0, pin_oe, pin_out}, 24'd3);
    @(negedge clk);
    chk("R12 pulse one cycle", {23'h0, pin_out}, 24'd0);

    // R12 toggle output with inverted polarity
    stop();
    wr(3'd1, 24'd0); wr(3'd2, 24'd2);
    wr(3'd0, cw(1, 0, 0, 1, 4'd2));
    @(negedge clk);
    chk("R12 toggle idle inverted", {23'h0, pin_out}, 24'd1);
    ticks(3);
    chk("R12 toggle first match", {23'h0, pin_out}, 24'd0);
    ticks(3);
    chk("R12 toggle second match", {23'h0, pin_out}, 24'd1);

    // R12 PWM output
    stop();
    wr(3'd1, 24'd0); wr(3'd2, 24'd2);
    wr(3'd0, cw(1, 0, 0, 0, 4'd7));
    ticks(1);
    chk("R12 pwm active on load", {22'h0, pin_oe, pin_out}, 24'd3);
    ticks(2);
    chk("R12 pwm inactive at compare", {23'h0, pin_out}, 24'd0);
    ticks(1);
    chk("R12 pwm active on reload", {23'h0, pin_out}, 24'd1);

    // R13 watchdog toggle and restart
    stop();
    wr(3'd1, 24'hFFFFFE); wr(3'd2, 24'd10);
    wr(3'd0, cw(1, 0, 1, 0, 4'd10));
    ticks(3);
    chk("R13 toggle on overflow", {23'h0, pin_out}, 24'd1);
    chk("R13 irq_ovf", {23'h0, irq_ovf}, 24'd1);
    wr(3'd1, 24'h000100);
    rd(3'd3, v); chk("R13 load write restarts", v, 24'h000100);
    ticks(1);
    rd(3'd3, v); chk("R13 counting after restart", v, 24'h000101);

    // R13 watchdog pulse
    stop();
    wr(3'd1, 24'hFFFFFF);
    wr(3'd0, cw(1, 0, 0, 0, 4'd9));
    ticks(1);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R13 pulse on overflow", {23'h0, pin_out}, 24'd1);
    @(negedge clk);
    chk("R13 pulse one cycle", {23'h0, pin_out}, 24'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule